// File: doc/BRIEF.md
# Suspendable Lifting Wavelet Line Engine

This block runs the one-dimensional 9/7 lifting wavelet transform along an image row. Sample pairs go in and low-pass/high-pass coefficient pairs come out. It does not finish a row in one pass. It works through a row in fixed segments of `SEG_PAIRS` input pairs, which is `r = 2*SEG_PAIRS` samples. After each segment it stops, so that a column engine can start on the coefficients already produced. At the stop it writes its whole lifting context to an external row context buffer that holds four words per row. When the next segment of that row is started, it reads those four words back and carries on as if it had never stopped. Several rows can therefore be interleaved segment by segment.

A segment is started with a command that carries the row number and the segment number within the row. Segment 0 begins a new row. It does no restore, and it mirrors the first samples to emulate symmetric extension at the left edge. A `seg_done` pulse marks the end of the context save. The right-edge extension samples are supplied by the source as ordinary input pairs.

Top module: `dwt_seg_line`

## Requirements
- R1: After reset the block is idle: `cmd_ready`=1, `in_ready`=0, `out_valid`=0, `seg_done`=0, and neither `ctx_wr_en` nor `ctx_rd_en` is asserted.
- R2: For a row x[0..], pair k holds even sample x[2k] on `in_even` and odd sample x[2k+1] on `in_odd`. Each lifting step adds two separately rounded products to its base value. The products are R(q,v) = floor((q*v + 8192)/16384), wrapped to DW bits signed. The steps are, in order: predict-1 with q=-25987 (odd from evens), update-1 with q=-868 (even from odds), predict-2 with q=14466, and update-2 with q=7266. The outputs are `out_lo` = R(13318, update-2 result) and `out_hi` = R(20155, predict-2 result). All sums wrap to DW bits.
- R3: Left-edge mirroring: the missing left neighbours are taken as x[-n] = x[n]. Segment 0 does no context read. Row pairs 0 and 1 give no output. The pair with row index k≥2 gives low coefficient L[k-2] and high coefficient H[k-2], where H[j] comes from odd sample 2j+1.
- R4: `out_valid` is high exactly in the cycle after an input pair is accepted (`in_valid` and `in_ready` high at a clock edge) whose row pair index is 2 or more.
- R5: One command accepts exactly SEG_PAIRS input pairs. `in_ready` is high only while a segment is running. Input offered at other times is ignored.
- R6: After the last pair of a segment, the block writes four context words on four consecutive cycles to addresses row*4+0, +1, +2, +3. `seg_done` is high only in the cycle of the fourth write, and reads and writes never overlap.
- R7: A command with segment number above 0 first reads addresses row*4+0..3 on four consecutive cycles. `ctx_rdata` must be valid in the cycle after its read enable. After the reads, input is accepted.
- R8: The coefficients of a row computed in suspended segments, with other rows' segments interleaved in between, equal bit for bit those of an uninterrupted run of the same row.
- R9: `cmd_ready` is high only when idle, and it drops in the cycle after a command is taken. A command offered while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Segment command offered |
| cmd_ready | output | 1 | Block idle, command taken on this edge |
| cmd_row | input | ROW_W | Row whose segment is to run |
| cmd_seg | input | SEG_W | Segment number within the row, 0 starts a row |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Segment running, pair accepted |
| in_even | input | DW | Even sample of the pair, signed |
| in_odd | input | DW | Odd sample of the pair, signed |
| out_valid | output | 1 | Coefficient pair valid |
| out_lo | output | DW | Low-pass coefficient, signed |
| out_hi | output | DW | High-pass coefficient, signed |
| ctx_wr_en | output | 1 | Context buffer write strobe |
| ctx_rd_en | output | 1 | Context buffer read strobe |
| ctx_addr | output | ROW_W+2 | Context buffer address, row*4+word |
| ctx_wdata | output | DW | Context word to store |
| ctx_rdata | input | DW | Context word read, valid one cycle after read strobe |
| seg_done | output | 1 | Context save of the segment complete |

## Verification
The assertions watch the protocol on every cycle. Outputs follow accepted pairs, the context port never reads and writes at once, read bursts are contiguous, `seg_done` sits on a write, a taken command drops `cmd_ready`, restore and input acceptance never coincide, and a segment that ends moves into the save. Only the bench scenarios can show the arithmetic results. They check the coefficients against an uninterrupted reference, the mirrored left edge and the missing first two outputs, the context addresses per row, and that rows interleaved through the shared buffer stay independent. They also check that input and commands offered while idle or busy leave the results unchanged.

// File: rtl/dwt_seg_pkg.sv
package dwt_seg_pkg;
  localparam int CF_W    = 16;
  localparam int CF_FRAC = 14;

  // lifting constants, signed Q2.14
  localparam logic signed [CF_W-1:0] Q_PRED1 = -16'sd25987;
  localparam logic signed [CF_W-1:0] Q_UPD1  = -16'sd868;
  localparam logic signed [CF_W-1:0] Q_PRED2 = 16'sd14466;
  localparam logic signed [CF_W-1:0] Q_UPD2  = 16'sd7266;
  localparam logic signed [CF_W-1:0] Q_LOW   = 16'sd13318;
  localparam logic signed [CF_W-1:0] Q_HIGH  = 16'sd20155;

  localparam int CTX_WORDS = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_SAVE} seg_state_t;
endpackage

// File: rtl/lift_rmul.sv
module lift_rmul #(
  parameter int DW = 18,
  parameter logic signed [dwt_seg_pkg::CF_W-1:0] KV = 16'sd0
) (
  input  logic signed [DW-1:0] v,
  output logic signed [DW-1:0] p
);
  import dwt_seg_pkg::*;
  localparam int PW = DW + CF_W;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (CF_FRAC - 1);

  logic signed [PW-1:0] ve, ke, full, sh;

  always_comb begin
    ve   = PW'(v);
    ke   = PW'(KV);
    full = ve * ke + HALF;
    sh   = full >>> CF_FRAC;
    p    = sh[DW-1:0];
  end
endmodule

// File: rtl/lift_core.sv
module lift_core #(
  parameter int DW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic [1:0]           ph,
  input  logic signed [DW-1:0] e,
  input  logic signed [DW-1:0] o,
  input  logic                 ld_en,
  input  logic [1:0]           ld_idx,
  input  logic [DW-1:0]        ld_data,
  output logic [3:0][DW-1:0]   ctx_q,
  output logic                 ov,
  output logic signed [DW-1:0] lo,
  output logic signed [DW-1:0] hi
);
  import dwt_seg_pkg::*;

  logic signed [DW-1:0] s1, s2, s3, s4;
  logic signed [DW-1:0] ta, tb, tc, td, y1, y2, y3, y4, lo_n, hi_n;

  lift_rmul #(.DW(DW), .KV(Q_PRED1)) m_a (.v(e),  .p(ta));
  lift_rmul #(.DW(DW), .KV(Q_UPD1))  m_b (.v(y1), .p(tb));
  lift_rmul #(.DW(DW), .KV(Q_PRED2)) m_c (.v(y2), .p(tc));
  lift_rmul #(.DW(DW), .KV(Q_UPD2))  m_d (.v(y3), .p(td));
  lift_rmul #(.DW(DW), .KV(Q_LOW))   m_l (.v(y4), .p(lo_n));
  lift_rmul #(.DW(DW), .KV(Q_HIGH))  m_h (.v(y3), .p(hi_n));

  // mirrored left edge doubles the single known neighbour term
  always_comb begin
    y1 = s1 + ta;
    y2 = s2 + tb + ((ph == 2'd1) ? tb : '0);
    y3 = s3 + tc;
    y4 = s4 + td + ((ph == 2'd2) ? td : '0);
  end

  assign ctx_q = {s4, s3, s2, s1};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; s3 <= '0; s4 <= '0;
      ov <= 1'b0; lo <= '0; hi <= '0;
    end else begin
      ov <= step && (ph >= 2'd2);
      if (step) begin
        s1 <= o + ta;
        s2 <= (ph == 2'd0) ? e : (e + tb);
        s3 <= y1 + tc;
        s4 <= (ph == 2'd1) ? y2 : (y2 + td);
        if (ph >= 2'd2) begin
          lo <= lo_n;
          hi <= hi_n;
        end
      end else if (ld_en) begin
        case (ld_idx)
          2'd0: s1 <= ld_data;
          2'd1: s2 <= ld_data;
          2'd2: s3 <= ld_data;
          default: s4 <= ld_data;
        endcase
      end
    end
  end

  // R7
  ld_step_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld_en && step));
endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl #(
  parameter int SEG_PAIRS = 4,
  parameter int ROW_W     = 3,
  parameter int SEG_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [SEG_W-1:0] cmd_seg,
  input  logic             in_valid,
  output logic             cmd_ready,
  output logic             in_ready,
  output logic             step,
  output logic [1:0]       ph,
  output logic             ld_en,
  output logic [1:0]       ld_idx,
  output logic             rq_rd,
  output logic             rq_wr,
  output logic [1:0]       rq_idx,
  output logic [ROW_W-1:0] rq_row,
  output logic             done_rq
);
  import dwt_seg_pkg::*;
  localparam int MAXC  = (SEG_PAIRS > 6) ? SEG_PAIRS : 6;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(SEG_PAIRS - 1);
  localparam logic [CNT_W-1:0] LOAD_END  = CNT_W'(CTX_WORDS + 1);
  localparam logic [CNT_W-1:0] SAVE_END  = CNT_W'(CTX_WORDS - 1);

  seg_state_t st;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] row_q;
  logic [1:0] rest_ph;
  int pairs_before;

  always_comb begin
    pairs_before = int'(cmd_seg) * SEG_PAIRS;
    rest_ph = (pairs_before >= 3) ? 2'd3 : 2'(pairs_before);
  end

  assign cmd_ready = (st == ST_IDLE);
  assign in_ready  = (st == ST_RUN);
  assign step      = in_valid && in_ready;
  assign rq_row    = row_q;

  always_comb begin
    rq_rd   = (st == ST_LOAD) && (cnt < CNT_W'(CTX_WORDS));
    rq_wr   = (st == ST_SAVE);
    rq_idx  = cnt[1:0];
    ld_en   = (st == ST_LOAD) && (cnt >= CNT_W'(2));
    ld_idx  = 2'(cnt - CNT_W'(2));
    done_rq = (st == ST_SAVE) && (cnt == SAVE_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; row_q <= '0; ph <= 2'd0;
    end else begin
      case (st)
        ST_IDLE: if (cmd_valid) begin
          row_q <= cmd_row;
          cnt   <= '0;
          if (cmd_seg == '0) begin
            ph <= 2'd0; st <= ST_RUN;
          end else begin
            ph <= rest_ph; st <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (cnt == LOAD_END) begin cnt <= '0; st <= ST_RUN; end
          else cnt <= cnt + 1'b1;
        end
        ST_RUN: if (step) begin
          ph <= (ph == 2'd3) ? 2'd3 : ph + 2'd1;
          if (cnt == LAST_PAIR) begin cnt <= '0; st <= ST_SAVE; end
          else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == SAVE_END) begin cnt <= '0; st <= ST_IDLE; end
          else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R5
  run_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == LAST_PAIR) |=> (st == ST_SAVE && !in_ready));
endmodule

// File: rtl/dwt_seg_line.sv
module dwt_seg_line #(
  parameter int DW        = 18,
  parameter int SEG_PAIRS = 4,
  parameter int ROWS      = 8,
  parameter int SEG_W     = 8,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int AW       = ROW_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [ROW_W-1:0]     cmd_row,
  input  logic [SEG_W-1:0]     cmd_seg,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_even,
  input  logic signed [DW-1:0] in_odd,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_lo,
  output logic signed [DW-1:0] out_hi,
  output logic                 ctx_wr_en,
  output logic                 ctx_rd_en,
  output logic [AW-1:0]        ctx_addr,
  output logic [DW-1:0]        ctx_wdata,
  input  logic [DW-1:0]        ctx_rdata,
  output logic                 seg_done
);
  logic step, ld_en, rq_rd, rq_wr, done_rq;
  logic [1:0] ph, ld_idx, rq_idx;
  logic [ROW_W-1:0] rq_row;
  logic [3:0][DW-1:0] ctx_q;

  seg_ctrl #(.SEG_PAIRS(SEG_PAIRS), .ROW_W(ROW_W), .SEG_W(SEG_W)) ctrl_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_row(cmd_row),
    .cmd_seg(cmd_seg), .in_valid(in_valid), .cmd_ready(cmd_ready),
    .in_ready(in_ready), .step(step), .ph(ph), .ld_en(ld_en),
    .ld_idx(ld_idx), .rq_rd(rq_rd), .rq_wr(rq_wr), .rq_idx(rq_idx),
    .rq_row(rq_row), .done_rq(done_rq));

  lift_core #(.DW(DW)) core_i (
    .clk(clk), .rst(rst), .step(step), .ph(ph), .e(in_even), .o(in_odd),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ctx_rdata), .ctx_q(ctx_q),
    .ov(out_valid), .lo(out_lo), .hi(out_hi));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_wr_en <= 1'b0; ctx_rd_en <= 1'b0; ctx_addr <= '0;
      ctx_wdata <= '0; seg_done <= 1'b0;
    end else begin
      ctx_wr_en <= rq_wr;
      ctx_rd_en <= rq_rd;
      ctx_addr  <= {rq_row, rq_idx};
      ctx_wdata <= ctx_q[rq_idx];
      seg_done  <= done_rq;
    end
  end

  // R4
  out_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));
  // R6
  ctx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctx_wr_en && ctx_rd_en));
  // R6
  done_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    seg_done |-> ctx_wr_en);
  // R7
  rd_burst_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctx_rd_en) |=> ctx_rd_en);
  // R9
  cmd_take_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

// File: tb/dwt_seg_line_tb_top.sv
module dwt_seg_line_tb_top;
  localparam int DW = 18, SP = 4, ROWS = 4, SEGS = 4;
  localparam int P = SEGS * SP, NS = 2 * P, NO = P - 2;
  localparam int RW = 2;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic cmd_valid = 0, in_valid = 0;
  logic [RW-1:0] cmd_row = '0;
  logic [7:0] cmd_seg = '0;
  logic signed [DW-1:0] in_even = '0, in_odd = '0;
  logic cmd_ready, in_ready, out_valid, ctx_wr_en, ctx_rd_en, seg_done;
  logic signed [DW-1:0] out_lo, out_hi;
  logic [RW+1:0] ctx_addr;
  logic [DW-1:0] ctx_wdata, ctx_rdata;
  logic [DW-1:0] mem [4*ROWS];

  dwt_seg_line #(.DW(DW), .SEG_PAIRS(SP), .ROWS(ROWS), .SEG_W(8)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_row(cmd_row), .cmd_seg(cmd_seg), .in_valid(in_valid),
    .in_ready(in_ready), .in_even(in_even), .in_odd(in_odd),
    .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi),
    .ctx_wr_en(ctx_wr_en), .ctx_rd_en(ctx_rd_en), .ctx_addr(ctx_addr),
    .ctx_wdata(ctx_wdata), .ctx_rdata(ctx_rdata), .seg_done(seg_done));

  always @(posedge clk) begin
    if (ctx_wr_en) mem[ctx_addr] <= ctx_wdata;
    if (ctx_rd_en) ctx_rdata <= mem[ctx_addr];
  end

  int total = 0, bad = 0;
  int cur_row = 0, wseq = 0, rseq = 0, wcnt = 0, rcnt = 0;
  longint xs [ROWS][NS];
  longint refl [ROWS][NO];
  longint refh [ROWS][NO];
  int oidx [ROWS];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint wrapv(longint t);
    longint w = t & ((64'sd1 << DW) - 1);
    if (w >= (64'sd1 << (DW - 1))) w -= (64'sd1 << DW);
    return w;
  endfunction

  function automatic longint rq(longint q, longint v);
    longint t = (q * v + 8192) >>> 14;
    return wrapv(t);
  endfunction

  // R2 R3 reference: uninterrupted row with mirrored left edge
  task automatic build_ref(int row, int kind);
    longint y1o [P];
    longint y2e [P];
    longint y3o [P];
    for (int i = 0; i < NS; i++) begin
      case (kind)
        0: xs[row][i] = ((i * 37 + row * 101) % 400) - 200;
        1: xs[row][i] = (i % 2 == 0) ? (300 + i) : -(300 + i);
        2: xs[row][i] = 0;
        default: xs[row][i] = (i < 10) ? -500 : 700;
      endcase
    end
    for (int i = 0; i < P - 1; i++)
      y1o[i] = wrapv(xs[row][2*i+1] + rq(-25987, xs[row][2*i]) + rq(-25987, xs[row][2*i+2]));
    for (int i = 0; i < P - 1; i++)
      y2e[i] = wrapv(xs[row][2*i] + rq(-868, (i == 0) ? y1o[0] : y1o[i-1]) + rq(-868, y1o[i]));
    for (int i = 0; i < P - 2; i++)
      y3o[i] = wrapv(y1o[i] + rq(14466, y2e[i]) + rq(14466, y2e[i+1]));
    for (int j = 0; j < NO; j++) begin
      longint y4 = wrapv(y2e[j] + rq(7266, (j == 0) ? y3o[0] : y3o[j-1]) + rq(7266, y3o[j]));
      refl[row][j] = rq(13318, y4);
      refh[row][j] = rq(20155, y3o[j]);
    end
    oidx[row] = 0;
  endtask

  // monitor: coefficient values and context addresses
  always @(negedge clk) if (!rst) begin
    if (out_valid) begin
      if (oidx[cur_row] < NO) begin
        chk(out_lo == refl[cur_row][oidx[cur_row]], "R8", "low coef", out_lo, refl[cur_row][oidx[cur_row]]);
        chk(out_hi == refh[cur_row][oidx[cur_row]], "R2", "high coef", out_hi, refh[cur_row][oidx[cur_row]]);
      end else chk(0, "R3", "extra output index", oidx[cur_row], NO - 1);
      oidx[cur_row]++;
    end
    if (ctx_wr_en) begin
      chk(ctx_addr == cur_row * 4 + wseq, "R6", "write addr", ctx_addr, cur_row * 4 + wseq);
      chk(seg_done == (wseq == 3), "R6", "seg_done on write", seg_done, wseq == 3);
      wseq = (wseq + 1) % 4; wcnt++;
    end else chk(!seg_done, "R6", "seg_done without write", seg_done, 0);
    if (ctx_rd_en) begin
      chk(ctx_addr == cur_row * 4 + rseq, "R7", "read addr", ctx_addr, cur_row * 4 + rseq);
      rseq = (rseq + 1) % 4; rcnt++;
    end
  end

  // one segment; gap inserts idle cycles, busy offers a bogus command
  task automatic run_seg(int row, int seg, bit gap, bit busy);
    int w0 = wcnt, r0 = rcnt, o0;
    cur_row = row;
    o0 = oidx[row];
    @(negedge clk);
    cmd_valid = 1; cmd_row = RW'(row); cmd_seg = 8'(seg);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready, "R9", "cmd_ready after take", cmd_ready, 0);
    for (int p = 0; p < SP; p++) begin
      int g = seg * SP + p;
      in_even = DW'(xs[row][2*g]); in_odd = DW'(xs[row][2*g+1]); in_valid = 1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == (g >= 2), "R4", "out_valid after pair", out_valid, g >= 2);
      in_valid = 0;
      if (gap || busy) begin
        if (busy && p < SP - 1) begin
          cmd_valid = 1; cmd_row = RW'(row + 1); cmd_seg = 8'd3;
        end
        for (int k = 0; k < (p % 3) + 1; k++) begin
          @(negedge clk);
          chk(!out_valid, "R4", "out_valid in gap", out_valid, 0);
          if (busy) chk(!cmd_ready, "R9", "cmd_ready busy", cmd_ready, 0);
        end
        cmd_valid = 0;
      end
    end
    while (!seg_done) @(negedge clk);
    @(negedge clk);
    chk(wcnt - w0 == 4, "R6", "writes per segment", wcnt - w0, 4);
    chk(rcnt - r0 == ((seg == 0) ? 0 : 4), (seg == 0) ? "R3" : "R7", "reads per segment", rcnt - r0, (seg == 0) ? 0 : 4);
    chk(oidx[row] - o0 == ((seg == 0) ? SP - 2 : SP), "R3", "outputs per segment", oidx[row] - o0, (seg == 0) ? SP - 2 : SP);
    chk(cmd_ready, "R9", "idle after segment", cmd_ready, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready, "R1", "cmd_ready", cmd_ready, 1);
    chk(!in_ready, "R1", "in_ready", in_ready, 0);
    chk(!out_valid, "R1", "out_valid", out_valid, 0);
    chk(!ctx_wr_en && !ctx_rd_en, "R1", "ctx strobes", ctx_wr_en | ctx_rd_en, 0);
    chk(!seg_done, "R1", "seg_done", seg_done, 0);
  endtask

  task automatic t_idle_input();
    in_valid = 1; in_even = 18'sd900; in_odd = -18'sd900;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!in_ready && !out_valid, "R5", "idle input ignored", out_valid | in_ready, 0);
    end
    in_valid = 0;
  endtask

  task automatic t_one_row(int row, int kind);
    build_ref(row, kind);
    for (int s = 0; s < SEGS; s++) run_seg(row, s, 0, 0);
    chk(oidx[row] == NO, "R8", "row output count", oidx[row], NO);
  endtask

  task automatic t_interleave();
    for (int r = 1; r < ROWS; r++) build_ref(r, r % 4);
    for (int s = 0; s < SEGS; s++)
      for (int r = 1; r < ROWS; r++) run_seg(r, s, 0, 0);
    for (int r = 1; r < ROWS; r++)
      chk(oidx[r] == NO, "R8", "interleaved row count", oidx[r], NO);
  endtask

  task automatic t_gaps_busy();
    build_ref(0, 3);
    for (int s = 0; s < SEGS; s++) run_seg(0, s, 1, s % 2 == 1);
    chk(oidx[0] == NO, "R5", "gapped row count", oidx[0], NO);
  endtask

  bit fin = 0;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_idle_input();
    t_one_row(0, 0);
    t_one_row(0, 2);
    t_interleave();
    t_gaps_busy();
    t_idle_input();
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog run hung actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule